// File: doc/BRIEF.md
# CSR Read-Modify-Write Access Unit

This block carries out the three atomic control/status register instructions against a small machine-level register file. The three are swap, set-bits and clear-bits. A request carries an operation code, a 12-bit CSR address, a source operand, a flag that tells whether the source register index was nonzero, and the hart's current privilege level. One cycle later the block returns the value the CSR held before the access. If the access is not permitted, it flags an illegal instruction instead.

All three operations share one masked-write datapath: `new = (old & ~mask) | (value & mask)`.

| Operation | Mask | Write value |
|-----------|------|-------------|
| Swap | all ones | source operand |
| Set | source operand | all ones |
| Clear | source operand | zero |

When set or clear names register zero as the source, the mask is forced to zero, so the CSR is read without being written. The block refuses an access in any of these cases:

- the operation code is not defined;
- the address is not implemented;
- the address demands a higher privilege than the current one;
- the access would write a read-only CSR.

A refused access leaves every CSR untouched and returns zero.

Top module: `csr_rmw_unit`

## Requirements
- R1: Operation code 2'b01 (swap) returns the old CSR value and leaves the CSR holding the source operand, restricted to its implemented bits.
- R2: Operation code 2'b10 (set) with a nonzero source index returns the old value and leaves the CSR holding old OR source.
- R3: Operation code 2'b11 (clear) with a nonzero source index returns the old value and leaves the CSR holding old AND NOT source.
- R4: Set or clear with the source-index flag low uses a zero mask. It returns the old value, changes no CSR, and is legal even on a read-only CSR.
- R5: Swap writes the source operand whether or not the source-index flag is set.
- R6: The implemented addresses are 0x040, 0x140, 0x340, 0x341, 0xF12 and 0xF14. Any other address is refused.
- R7: Address bits [9:8] give the minimum privilege level. If they exceed the 2-bit privilege input, the access is refused, even when nothing would be written.
- R8: Addresses whose bits [11:10] are 2'b11 are read-only. An access to them with a nonzero mask is refused. Set with the flag high and a zero operand is legal.
- R9: Operation code 2'b00 is refused.
- R10: A response (`rsp_valid` high) appears exactly one clock after each request, and is low one clock after a cycle with no request. Back-to-back requests see each other's writes.
- R11: Bit 0 of CSR 0x341 always reads zero.
- R12: After reset the writable CSRs read zero, 0xF14 reads `HART_ID`, 0xF12 reads `ARCH_ID`, and `rsp_valid` is low.
- R13: A refused access returns zero data with `rsp_illegal` high and changes no CSR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 01 swap, 10 set, 11 clear, 00 undefined |
| req_addr | input | 12 | CSR address |
| req_src | input | XLEN | Source operand |
| req_src_nz | input | 1 | Source register index is nonzero |
| req_priv | input | 2 | Current privilege level (0 user … 3 machine) |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | XLEN | Old CSR value, zero on refusal |
| rsp_illegal | output | 1 | Access refused: illegal instruction |

## Verification
The hardest situations to reach are the ones where two refusal causes meet a zero mask. The clearest case is a read-only CSR accessed by set with the flag high but a zero operand. Another is a privileged CSR read through a zero-mask clear from a lower level. The bench reaches them by sweeping every operation, every listed and several unlisted addresses, every privilege level and both flag values, with pseudo-random operands. Directed accesses then cover the zero-operand read-only case and the hardwired low bit.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SWAP = 2'b01,
    OP_SET  = 2'b10,
    OP_CLR  = 2'b11
  } csr_op_e;

  localparam int NUM_CSR = 6;
  localparam int IDX_W   = $clog2(NUM_CSR);

  // table slots
  localparam int SLOT_USCR = 0;
  localparam int SLOT_SSCR = 1;
  localparam int SLOT_MSCR = 2;
  localparam int SLOT_MEPC = 3;
  localparam int SLOT_ARCH = 4;
  localparam int SLOT_HART = 5;

  function automatic logic [11:0] slot_addr(input int slot);
    case (slot)
      SLOT_USCR: slot_addr = 12'h040;
      SLOT_SSCR: slot_addr = 12'h140;
      SLOT_MSCR: slot_addr = 12'h340;
      SLOT_MEPC: slot_addr = 12'h341;
      SLOT_ARCH: slot_addr = 12'hF12;
      default:   slot_addr = 12'hF14;
    endcase
  endfunction

  function automatic bit slot_is_const(input int slot);
    slot_is_const = (slot == SLOT_ARCH) || (slot == SLOT_HART);
  endfunction

endpackage

// File: rtl/csr_rmw_decode.sv
module csr_rmw_decode
  import csr_rmw_pkg::*;
(
  input  logic [11:0]      addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             read_only,
  output logic [1:0]       min_priv
);

  logic [NUM_CSR-1:0] match;

  for (genvar g = 0; g < NUM_CSR; g++) begin : g_match
    assign match[g] = (addr == slot_addr(g));
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_CSR; i++) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit       = |match;
  assign read_only = (addr[11:10] == 2'b11);
  assign min_priv  = addr[9:8];

endmodule

// File: rtl/csr_rmw_mask.sv
module csr_rmw_mask
  import csr_rmw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] src,
  input  logic            src_nz,
  output logic [XLEN-1:0] mask,
  output logic [XLEN-1:0] wval,
  output logic            op_ok
);

  always_comb begin
    mask  = '0;
    wval  = '0;
    op_ok = 1'b1;
    case (csr_op_e'(op))
      OP_SWAP: begin
        mask = '1;
        wval = src;
      end
      OP_SET: begin
        mask = src_nz ? src : '0;
        wval = '1;
      end
      OP_CLR: begin
        mask = src_nz ? src : '0;
        wval = '0;
      end
      default: op_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/csr_rmw_regfile.sv
module csr_rmw_regfile
  import csr_rmw_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] HART_ID = 32'h0,
  parameter logic [31:0] ARCH_ID = 32'h5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [XLEN-1:0]         wdata,
  output logic [XLEN-1:0]         rdata,
  output logic [NUM_CSR*XLEN-1:0] flat
);

  logic [XLEN-1:0] cells [NUM_CSR];

  for (genvar g = 0; g < NUM_CSR; g++) begin : g_cell
    if (g == SLOT_HART) begin : g_hart
      assign cells[g] = XLEN'(HART_ID);
    end else if (g == SLOT_ARCH) begin : g_arch
      assign cells[g] = XLEN'(ARCH_ID);
    end else begin : g_rw
      localparam logic [XLEN-1:0] IMPL =
        (g == SLOT_MEPC) ? {{(XLEN-1){1'b1}}, 1'b0} : {XLEN{1'b1}};
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (we && idx == IDX_W'(g)) q <= wdata & IMPL;
      end
      assign cells[g] = q;
      if (g == SLOT_MEPC) begin : g_lsb_chk
        a_r11_mepc_lsb_zero: assert property (@(posedge clk) disable iff (rst)
          !q[0]);
      end
    end
    assign flat[g*XLEN +: XLEN] = cells[g];
  end

  assign rdata = cells[idx];

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] HART_ID = 32'h0,
  parameter logic [31:0] ARCH_ID = 32'h5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [11:0]     req_addr,
  input  logic [XLEN-1:0] req_src,
  input  logic            req_src_nz,
  input  logic [1:0]      req_priv,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_rdata,
  output logic            rsp_illegal
);

  logic                    hit, read_only, op_ok, access_ok, wr_en;
  logic [IDX_W-1:0]        idx;
  logic [1:0]              min_priv;
  logic [XLEN-1:0]         mask, wval, old_val, new_val;
  logic [NUM_CSR*XLEN-1:0] csr_flat;

  csr_rmw_decode u_dec (
    .addr      (req_addr),
    .hit       (hit),
    .idx       (idx),
    .read_only (read_only),
    .min_priv  (min_priv)
  );

  csr_rmw_mask #(.XLEN(XLEN)) u_mask (
    .op     (req_op),
    .src    (req_src),
    .src_nz (req_src_nz),
    .mask   (mask),
    .wval   (wval),
    .op_ok  (op_ok)
  );

  csr_rmw_regfile #(.XLEN(XLEN), .HART_ID(HART_ID), .ARCH_ID(ARCH_ID)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .idx   (idx),
    .wdata (new_val),
    .rdata (old_val),
    .flat  (csr_flat)
  );

  assign access_ok = op_ok && hit && (min_priv <= req_priv) &&
                     !(read_only && (|mask));
  assign new_val   = (old_val & ~mask) | (wval & mask);
  assign wr_en     = req_valid && access_ok && (|mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_illegal <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_rdata   <= access_ok ? old_val : '0;
        rsp_illegal <= !access_ok;
      end else begin
        rsp_illegal <= 1'b0;
      end
    end
  end

  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r10_no_rsp_when_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r13_refused_returns_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> (rsp_rdata == '0));
  a_r9_undefined_op: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_NONE) |=> rsp_illegal);
  a_r7_priv_too_low: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[9:8] > req_priv) |=> rsp_illegal);
  a_r8_swap_read_only: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[11:10] == 2'b11 && req_op == OP_SWAP) |=> rsp_illegal);
  a_r4_zero_index_no_write: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == OP_SET || req_op == OP_CLR) && !req_src_nz)
      |=> $stable(csr_flat));
  a_r13_refused_no_write: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !op_ok) |=> $stable(csr_flat));

endmodule

// File: tb/csr_rmw_unit_tb.sv
module csr_rmw_unit_tb;

  localparam int          XLEN = 32;
  localparam logic [31:0] HART = 32'h0000_0007;
  localparam logic [31:0] ARCH = 32'h0000_0015;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [1:0]      req_op = 2'b00;
  logic [11:0]     req_addr = '0;
  logic [XLEN-1:0] req_src = '0;
  logic            req_src_nz = 1'b0;
  logic [1:0]      req_priv = 2'd3;
  logic            rsp_valid, rsp_illegal;
  logic [XLEN-1:0] rsp_rdata;

  int total = 0;
  int bad = 0;
  logic [31:0] model [6];
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  csr_rmw_unit #(.XLEN(XLEN), .HART_ID(HART), .ARCH_ID(ARCH)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_src(req_src), .req_src_nz(req_src_nz),
    .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_illegal(rsp_illegal)
  );

  function automatic int slot_of(input logic [11:0] a);
    case (a)
      12'h040: slot_of = 0;
      12'h140: slot_of = 1;
      12'h340: slot_of = 2;
      12'h341: slot_of = 3;
      12'hF12: slot_of = 4;
      12'hF14: slot_of = 5;
      default: slot_of = -1;
    endcase
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    next_rand = x ^ (x << 5);
  endfunction

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {valid,illegal,data} actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic [1:0] op, input logic [11:0] a, input logic [31:0] s,
                     input logic nz, input logic [1:0] pv, input string force_tag);
    int sl;
    logic [31:0] mask, val, exp_rd;
    logic ok;
    string tag;
    sl = slot_of(a);
    mask = (op == 2'b01) ? 32'hFFFF_FFFF : (nz ? s : 32'h0);
    val  = (op == 2'b01) ? s : ((op == 2'b10) ? 32'hFFFF_FFFF : 32'h0);
    if (op == 2'b00) tag = "R9";
    else if (sl < 0) tag = "R6";
    else if (a[9:8] > pv) tag = "R7";
    else if (a[11:10] == 2'b11 && mask != 0) tag = "R8";
    else if (op != 2'b01 && !nz) tag = "R4";
    else if (op == 2'b01) tag = nz ? "R1" : "R5";
    else if (op == 2'b10) tag = "R2";
    else tag = "R3";
    if (force_tag != "") tag = force_tag;
    ok = (op != 2'b00) && (sl >= 0) && (a[9:8] <= pv) &&
         !(a[11:10] == 2'b11 && mask != 0);
    exp_rd = ok ? model[sl] : 32'h0;
    if (ok && mask != 0 && a[11:10] != 2'b11) begin
      model[sl] = (model[sl] & ~mask) | (val & mask);
      if (sl == 3) model[sl][0] = 1'b0;
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_src = s;
    req_src_nz = nz; req_priv = pv;
    @(posedge clk);
    #1;
    check(tag, {rsp_valid, rsp_illegal, rsp_rdata}, {1'b1, !ok, exp_rd});
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R10 idle", {rsp_valid, rsp_illegal, 32'h0}, {1'b0, 1'b0, 32'h0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] addrs [10];
    addrs = '{12'h040, 12'h140, 12'h340, 12'h341, 12'hF12, 12'hF14,
              12'h240, 12'h342, 12'h000, 12'hF15};
    for (int i = 0; i < 4; i++) model[i] = 32'h0;
    model[4] = ARCH; model[5] = HART;
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset", {rsp_valid, rsp_illegal, rsp_rdata}, 34'h0);
    @(negedge clk);
    rst = 1'b0;
    // reset contents, read without write
    for (int i = 0; i < 6; i++) txn(2'b10, addrs[i], 32'hFFFF_FFFF, 1'b0, 2'd3, "R12");
    idle_check();
    // exhaustive sweep
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 10; a++)
        for (int pv = 0; pv < 4; pv++)
          for (int nz = 0; nz < 2; nz++) begin
            seed = next_rand(seed);
            txn(op[1:0], addrs[a], seed, nz[0], pv[1:0], "");
          end
    idle_check();
    // read-only CSR: set with nonzero index but zero operand is legal
    txn(2'b10, 12'hF14, 32'h0, 1'b1, 2'd3, "R8 zero operand");
    txn(2'b11, 12'hF12, 32'h0, 1'b1, 2'd3, "R8 zero operand");
    // hardwired lsb
    txn(2'b01, 12'h341, 32'hFFFF_FFFF, 1'b1, 2'd3, "R11");
    txn(2'b10, 12'h341, 32'h0000_0001, 1'b1, 2'd3, "R11");
    txn(2'b10, 12'h341, 32'h0, 1'b0, 2'd3, "R11");
    // back-to-back dependency
    txn(2'b01, 12'h340, 32'hA5A5_0F0F, 1'b1, 2'd3, "R10");
    txn(2'b11, 12'h340, 32'h0000_0F00, 1'b1, 2'd3, "R10");
    txn(2'b10, 12'h340, 32'h1000_0000, 1'b1, 2'd3, "R10");
    txn(2'b10, 12'h340, 32'h0, 1'b0, 2'd3, "R10");
    // refused access leaves state: bad op then read
    txn(2'b00, 12'h040, 32'hFFFF_FFFF, 1'b1, 2'd3, "R13");
    txn(2'b10, 12'h040, 32'h0, 1'b0, 2'd0, "R13");
    // privileged read through zero mask from user level
    txn(2'b11, 12'h340, 32'h0, 1'b0, 2'd0, "R7");
    // final readback of all
    for (int i = 0; i < 6; i++) txn(2'b11, addrs[i], 32'hFFFF_FFFF, 1'b0, 2'd3, "R4 readback");
    idle_check();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule